// File: doc/BRIEF.md
# Register-Exchange Survivor Path Store

This block keeps the survivor sequence of every trellis state of a rate-1/2, constraint-length-3 convolutional decoder. A path metric stage hands it one decision vector per trellis step, one bit per state, together with a valid strobe. Each state owns one row of bit registers. On an accepted step, the row of each state is refilled from the row of the predecessor that its decision bit names. The copied contents move one stage towards the old end, and the input bit that leads into that state enters at the young end.

The rows are as deep as the traceback depth `TBD` (default 15). Survivor paths are taken to have merged within that many steps, so the oldest stage of one fixed row, picked by the `OUT_ROW` parameter, is the decoded bit. There is no memory and no read pointer. Latency is fixed at `TBD` accepted steps. An output strobe marks each step whose decoded bit is backed by a full window of history.

Top module: `rx_survivor_mem`

## Requirements
- R1: While reset is asserted, and after it is released, every row holds all zeros, `bit_o` is 0 and `bit_vld_o` is 0.
- R2: When `dec_vld_i` is 1, the row of state s (s = 0..3) is loaded from the row of predecessor p = ((2·s) mod 4) + `dec_vec_i[s]`. Stage j of p moves to stage j+1 of s, and the oldest stage of p is dropped.
- R3: On the same step, stage 0 of the row of state s is loaded with bit 1 of s, the input bit that leads into s. States 0 and 1 take 0; states 2 and 3 take 1.
- R4: `bit_o` always equals the oldest stage (stage TBD-1) of the row of state `OUT_ROW`, for any `OUT_ROW` from 0 to 3.
- R5: `bit_vld_o` is 1 in the cycle after an accepted step, but only when at least TBD steps, that one included, have been accepted since reset. It is 0 in every other cycle.
- R6: When `dec_vld_i` is 0, all rows keep their contents, so `bit_o` does not change.
- R7: A decoded bit comes from the step TBD-1 steps before the newest accepted step. Stages not yet reached by any accepted step read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| dec_vld_i | input | 1 | The decision vector is valid this cycle |
| dec_vec_i | input | 4 | One survivor decision per state; bit s selects the predecessor of state s |
| bit_o | output | 1 | Oldest stage of the chosen row |
| bit_vld_o | output | 1 | `bit_o` is a decoded bit backed by a full window |

## Verification
The assertions assume that `dec_vld_i` and `dec_vec_i` are settled before each rising edge, and that `dec_vld_i` is low while reset and its synchronizer are active. Any 4-bit decision vector is legal, so no property depends on survivor paths having merged. The stimulus changes inputs only on falling edges and keeps the strobe low until the synchronizer has released. Every value of the decision vector is applied both as a long constant run and mixed at random with idle gaps. Expected outputs come from a trace-back over the bench's stored history of decisions.

// File: rtl/rx_pkg.sv
package rx_pkg;

  function automatic int pred_base(input int st, input int nst);
    return (st << 1) & (nst - 1);
  endfunction

  function automatic int head_bit(input int st, input int m);
    return (st >> (m - 1)) & 1;
  endfunction

endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rx_sm_row.sv
module rx_sm_row #(
  parameter int TBD = 15,
  parameter int M   = 2,
  parameter int ST  = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           sel_i,
  input  logic [TBD-2:0] cand0_i,
  input  logic [TBD-2:0] cand1_i,
  output logic [TBD-1:0] row_o
);
  localparam logic HEAD = 1'(rx_pkg::head_bit(ST, M));

  logic [TBD-1:0] row_q, row_d;
  logic [TBD-2:0] pick;

  assign pick = sel_i ? cand1_i : cand0_i;

  always_comb begin
    row_d = row_q;
    if (en_i) row_d = {pick, HEAD};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row_o = row_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(row_q));
  p_from_pred0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !sel_i) |=> (row_q[TBD-1:1] == $past(cand0_i)));
  p_from_pred1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sel_i) |=> (row_q[TBD-1:1] == $past(cand1_i)));
  p_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (row_q[0] == HEAD));
endmodule

// File: rtl/rx_sm_vcnt.sv
module rx_sm_vcnt #(
  parameter int TBD = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic full_vld_o
);
  localparam int CW = $clog2(TBD + 1);
  localparam logic [CW-1:0] LIM  = CW'(TBD);
  localparam logic [CW-1:0] LIM1 = CW'(TBD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          vld_q, vld_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step_i && (cnt_q != LIM)) cnt_d = cnt_q + CW'(1);
    vld_d = step_i && (cnt_q >= LIM1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign full_vld_o = vld_q;

  p_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (cnt_q == LIM));
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(cnt_q));
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
endmodule

// File: rtl/rx_survivor_mem.sv
module rx_survivor_mem #(
  parameter int K       = 3,
  parameter int TBD     = 15,
  parameter int OUT_ROW = 0,
  localparam int M      = K - 1,
  localparam int NST    = 1 << M
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dec_vld_i,
  input  logic [NST-1:0] dec_vec_i,
  output logic           bit_o,
  output logic           bit_vld_o
);
  logic                     rst_sync_n;
  logic [NST-1:0][TBD-1:0]  rows;
  logic [NST-1:0]           oldest;
  logic                     unused_oldest;

  rx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar s = 0; s < NST; s++) begin : g_row
    localparam int P0 = rx_pkg::pred_base(s, NST);
    localparam int P1 = P0 + 1;

    rx_sm_row #(.TBD(TBD), .M(M), .ST(s)) u_row (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .en_i    (dec_vld_i),
      .sel_i   (dec_vec_i[s]),
      .cand0_i (rows[P0][TBD-2:0]),
      .cand1_i (rows[P1][TBD-2:0]),
      .row_o   (rows[s])
    );

    assign oldest[s] = rows[s][TBD-1];
  end

  rx_sm_vcnt #(.TBD(TBD)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .step_i     (dec_vld_i),
    .full_vld_o (bit_vld_o)
  );

  assign bit_o         = oldest[OUT_ROW];
  assign unused_oldest = ^oldest;

  p_vld_after_step_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_vld_o |-> $past(dec_vld_i));
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dec_vld_i |=> $stable(bit_o));
  p_reset_out_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!bit_o && !bit_vld_o));
endmodule

// File: tb/rx_survivor_mem_tb_top.sv
module rx_survivor_mem_tb_top;
  localparam int TB = 15;

  logic       clk;
  logic       rst_n;
  logic       dec_vld;
  logic [3:0] dec_vec;
  logic       bit0, vld0, bit3, vld3;

  int checks;
  int errors;
  int n_acc;
  logic last_v;
  logic [3:0] hist [0:4095];

  rx_survivor_mem #(.K(3), .TBD(TB), .OUT_ROW(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_vld_i(dec_vld), .dec_vec_i(dec_vec),
    .bit_o(bit0), .bit_vld_o(vld0)
  );

  rx_survivor_mem #(.K(3), .TBD(TB), .OUT_ROW(3)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .dec_vld_i(dec_vld), .dec_vec_i(dec_vec),
    .bit_o(bit3), .bit_vld_o(vld3)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic trace_bit(input int n, input int st);
    int s;
    s = st;
    for (int j = 0; j < TB; j++) begin
      if (n - j < 1) return 1'b0;
      if (j == TB - 1) return 1'((s >> 1) & 1);
      s = ((s << 1) & 3) | int'(hist[n - j][s]);
    end
    return 1'b0;
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (accepted %0d)", req, act, exp, n_acc);
    end
  endtask

  task automatic check_outs();
    logic ev;
    ev = last_v && (n_acc >= TB);
    chk(vld0, ev, "R5 valid row0");
    chk(vld3, ev, "R5 valid row3");
    chk(bit0, trace_bit(n_acc, 0), "R2/R3/R7 bit row0");
    chk(bit3, trace_bit(n_acc, 3), "R4 bit row3");
  endtask

  task automatic step(input logic v, input logic [3:0] d);
    dec_vld = v;
    dec_vec = d;
    @(posedge clk);
    if (v) begin
      n_acc++;
      hist[n_acc] = d;
    end
    last_v = v;
    @(negedge clk);
    check_outs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    dec_vld = 1'b0;
    dec_vec = 4'h0;
    #2;
    chk(bit0, 1'b0, "R1 bit in reset");
    chk(vld0, 1'b0, "R1 valid in reset");
    chk(bit3, 1'b0, "R1 bit3 in reset");
    repeat (3) @(negedge clk);
    rst_n  = 1'b1;
    n_acc  = 0;
    last_v = 1'b0;
    repeat (4) @(negedge clk);
    chk(bit0, 1'b0, "R1 bit after release");
    chk(vld0, 1'b0, "R1 valid after release");
    chk(bit3, 1'b0, "R1 bit3 after release");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    n_acc  = 0;
    last_v = 1'b0;
    rst_n  = 1'b0;
    dec_vld = 1'b0;
    dec_vec = 4'h0;
    do_reset();

    // R2 R3: every decision vector held constant over more than a window
    for (int v = 0; v < 16; v++) begin
      for (int k = 0; k < TB + 5; k++) step(1'b1, 4'(v));
    end

    // R6: idle cycles with changing vectors leave outputs untouched
    for (int k = 0; k < 20; k++) step(1'b0, 4'(k));

    do_reset();

    // R5 R7: fill window one step at a time, valid must not appear early
    for (int k = 0; k < TB + 2; k++) step(1'b1, 4'((k * 5) & 15));

    // mixed stream with random gaps
    for (int k = 0; k < 3000; k++) begin
      logic v;
      v = ($urandom_range(0, 3) != 0);
      step(v, 4'($urandom_range(0, 15)));
    end

    // R1: reset mid-stream then restart
    do_reset();
    for (int k = 0; k < 2 * TB; k++) step(k[0], 4'($urandom_range(0, 15)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule